// File: doc/BRIEF.md
# Split Up/Down Modulo-6 Counter

The block counts from 0 to 5 and back, wrapping in either direction. Instead of one 3-bit state register, it uses two small state machines with two flip-flops each. The low machine covers counts 0, 1 and 2. The high machine covers counts 3, 4 and 5. Each machine has a fourth, idle code that it parks in while the other machine owns the count.

Control moves between the machines only at the 2/3 and 5/0 boundaries. The parked machine watches the live machine's state and the direction inputs. When the live machine is at its edge and a step would cross it, the live machine drops to idle and the parked one wakes in the matching state, both on the same clock edge.

A step happens on a clock edge where exactly one of the two direction inputs is high. If both inputs are high, or both are low, the count holds. The 3-bit count is decoded from whichever machine is awake.

Top module: `updown_split_counter`

## Requirements
- R1: While rst_n is low, the count is 0. Reset places the low machine at count 0 and parks the high machine. This holds even when reset arrives in the middle of a count.
- R2: With up=1 and down=0, a count below 5 rises by one on the next clock edge.
- R3: With up=1 and down=0, a count of 5 becomes 0 on the next clock edge. Ownership passes from the high machine to the low machine.
- R4: With down=1 and up=0, a count above 0 falls by one on the next clock edge.
- R5: With down=1 and up=0, a count of 0 becomes 5 on the next clock edge. Ownership passes from the low machine to the high machine.
- R6: Stepping up from 2 gives 3. The low machine parks and the high machine wakes on the same edge.
- R7: Stepping down from 3 gives 2. The high machine parks and the low machine wakes on the same edge.
- R8: When up and down are both high, or both low, the count is unchanged on the next clock edge.
- R9: In every cycle outside reset, exactly one machine is awake, and the count stays in the range 0 to 5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| up | input | 1 | Step request toward higher counts |
| down | input | 1 | Step request toward lower counts |
| count | output | 3 | Current count, 0 to 5 |

## Verification
The bench concentrates on the four handoff edges: 2 to 3, 3 to 2, 5 to 0 and 0 to 5. Each is crossed many times in both directions, including turns taken right at a boundary.

A design with a wrong wake condition would show one of two failures:
- If both machines were left parked, the count would freeze or read as garbage.
- If both machines were left awake, the count would jump back into the low half.

Cycles with both inputs high or both low are mixed in at the boundaries, so that a premature handoff would show up as a moved count. A reset issued mid-count checks that the high machine is parked and the low machine restarts at 0.

// File: rtl/updown_split_counter.sv
`timescale 1ns/1ps
module updown_split_counter (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       up,
  input  logic       down,
  output logic [2:0] count
);
  localparam logic [1:0] LO_0 = 2'd0, LO_1 = 2'd1, LO_2 = 2'd2, LO_PARK = 2'd3;
  localparam logic [1:0] HI_3 = 2'd0, HI_4 = 2'd1, HI_5 = 2'd2, HI_PARK = 2'd3;

  logic [1:0] lo_q, lo_d, hi_q, hi_d;
  logic       go_up, go_dn;
  logic       lo_idle, hi_idle;

  assign go_up   = up & ~down;
  assign go_dn   = down & ~up;
  assign lo_idle = (lo_q == LO_PARK);
  assign hi_idle = (hi_q == HI_PARK);

  always_comb begin
    lo_d = lo_q;
    case (lo_q)
      LO_PARK: begin
        if (go_up && hi_q == HI_5)      lo_d = LO_0;
        else if (go_dn && hi_q == HI_3) lo_d = LO_2;
      end
      LO_0: begin
        if (go_up)      lo_d = LO_1;
        else if (go_dn) lo_d = LO_PARK;
      end
      LO_1: begin
        if (go_up)      lo_d = LO_2;
        else if (go_dn) lo_d = LO_0;
      end
      default: begin
        if (go_up)      lo_d = LO_PARK;
        else if (go_dn) lo_d = LO_1;
      end
    endcase
  end

  always_comb begin
    hi_d = hi_q;
    case (hi_q)
      HI_PARK: begin
        if (go_up && lo_q == LO_2)      hi_d = HI_3;
        else if (go_dn && lo_q == LO_0) hi_d = HI_5;
      end
      HI_3: begin
        if (go_up)      hi_d = HI_4;
        else if (go_dn) hi_d = HI_PARK;
      end
      HI_4: begin
        if (go_up)      hi_d = HI_5;
        else if (go_dn) hi_d = HI_3;
      end
      default: begin
        if (go_up)      hi_d = HI_PARK;
        else if (go_dn) hi_d = HI_4;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= LO_0;
      hi_q <= HI_PARK;
    end else begin
      lo_q <= lo_d;
      hi_q <= hi_d;
    end
  end

  assign count = lo_idle ? (3'd3 + {1'b0, hi_q}) : {1'b0, lo_q};
endmodule

module updown_split_counter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       up,
  input logic       down,
  input logic [2:0] count,
  input logic       lo_idle,
  input logic       hi_idle
);
  AST_ONE_AWAKE: assert property (@(posedge clk) disable iff (!rst_n) lo_idle != hi_idle); // R9
  AST_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n) count <= 3'd5); // R9
  AST_UP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (up && !down && count != 3'd5) |=> count == $past(count) + 3'd1); // R2
  AST_UP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (up && !down && count == 3'd5) |=> (count == 3'd0 && !lo_idle)); // R3
  AST_DN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (down && !up && count != 3'd0) |=> count == $past(count) - 3'd1); // R4
  AST_DN_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (down && !up && count == 3'd0) |=> (count == 3'd5 && lo_idle)); // R5
  AST_HAND_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (up && !down && count == 3'd2) |=> (lo_idle && !hi_idle)); // R6
  AST_HAND_DN: assert property (@(posedge clk) disable iff (!rst_n)
    (down && !up && count == 3'd3) |=> (hi_idle && !lo_idle)); // R7
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (up == down) |=> $stable(count)); // R8
endmodule

bind updown_split_counter updown_split_counter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .up(up), .down(down), .count(count),
  .lo_idle(lo_idle), .hi_idle(hi_idle)
);

// File: tb/updown_split_counter_tb.sv
`timescale 1ns/1ps
module updown_split_counter_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       up = 1'b0;
  logic       down = 1'b0;
  logic [2:0] count;
  int         checks = 0;
  int         errors = 0;
  int         model = 0;
  bit         in_reset = 1'b1;

  updown_split_counter u_dut (.clk(clk), .rst_n(rst_n), .up(up), .down(down), .count(count));

  always #4 clk = ~clk;

  always @(posedge clk) begin
    if (in_reset) model = 0;
    else if (up && !down) model = (model + 1) % 6;
    else if (down && !up) model = (model + 5) % 6;
  end

  task automatic check(input string tag);
    checks++;
    if (count > 3'd5 || int'(count) != model) begin
      errors++;
      $display("FAIL %s count=%0d expected=%0d", tag, count, model);
    end
  endtask

  task automatic step(input bit u, input bit d);
    int    prev = model;
    string tag;
    if (u == d)          tag = "R8";
    else if (u) tag = (prev == 5) ? "R3" : (prev == 2) ? "R6" : "R2";
    else        tag = (prev == 0) ? "R5" : (prev == 3) ? "R7" : "R4";
    up = u; down = d;
    @(posedge clk);
    @(negedge clk);
    check(tag);
    check("R9");
  endtask

  task automatic do_reset();
    up = 1'b0; down = 1'b0;
    rst_n = 1'b0; in_reset = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1");
    rst_n = 1'b1; in_reset = 1'b0;
    @(negedge clk);
    check("R1");
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired count=%0d expected=%0d", count, model);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int lfsr = 32'h1ACE;
    @(negedge clk);
    do_reset();
    for (int i = 0; i < 14; i++) step(1'b1, 1'b0);
    for (int i = 0; i < 14; i++) step(1'b0, 1'b1);
    step(1'b1, 1'b1);
    step(1'b0, 1'b0);
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0);
    step(1'b1, 1'b1);
    step(1'b0, 1'b1);
    step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    step(1'b0, 1'b1);
    for (int i = 0; i < 3; i++) step(1'b0, 1'b1);
    step(1'b1, 1'b0);
    step(1'b0, 1'b1);
    step(1'b1, 1'b1);
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      step(lfsr[0], lfsr[3]);
    end
    while (model != 4) step(1'b1, 1'b0);
    do_reset();
    step(1'b0, 1'b1);
    step(1'b1, 1'b0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule